// File: doc/BRIEF.md
# Physical memory protection checker

This block guards physical memory. It holds a small table of protection entries. Each entry has an 8-bit configuration byte and a 32-bit address word that holds physical address bits 33:2. The configuration byte picks how the entry's region is found: off, top-of-range, a 4-byte slot, or a naturally aligned power-of-two block. It also grants read, write and execute rights and can lock the entry.

Software loads the table through a one-cycle write port. The port carries an entry index, a select between the configuration byte and the address word, and the data. The port answers each write at once with an accept flag. A refused write leaves the table unchanged.

Each access presents an address, an access kind and a privilege level. The block answers in the same cycle with allow, or with fault and the kind of access that faulted. The lowest-numbered matching entry decides the result. Machine mode is bound only by locked entries.

Top module: `pmp_guard`

## Requirements
- R1: While reset is held, and after reset, every configuration byte and address word is zero. The active-rule count and the lock flag read 0, and every access is allowed.
- R2: Configuration byte bit 0 grants read (access kind 0), bit 1 grants write (kind 1) and bit 2 grants execute (kind 2). A matched entry allows an access only when the granted bit for that kind is set. Kind 3 has no granting bit.
- R3: Configuration bits 4:3 select the match mode: 0 off, 1 top-of-range, 2 four-byte, 3 power-of-two. An entry in mode 0 never matches.
- R4: In top-of-range mode, entry i matches when (address word of entry i-1) × 4 ≤ address < (its own word) × 4. Entry 0 uses a lower bound of 0.
- R5: In four-byte mode, an entry matches exactly the 4 bytes starting at its word × 4.
- R6: In power-of-two mode, let t be the number of trailing ones in the word. The entry covers 2^(t+3) bytes, aligned to that size, that contain the word × 4.
- R7: When several entries match, the lowest-numbered one decides.
- R8: When no entry matches, machine mode (privilege 3) is allowed. Privilege 0, 1 or 2 is faulted if at least one entry is in a mode other than off, and is allowed otherwise.
- R9: Configuration bit 7 locks an entry until reset. A write to a locked entry's byte or word is refused: accept reads 0 and nothing changes. A write to the address word of the entry just below a locked top-of-range entry is also refused. Writes to that lower entry's configuration byte are still accepted.
- R10: For a machine-mode access, a matching unlocked entry allows the access. A matching locked entry applies its rights.
- R11: The rule count equals the number of entries whose mode is not off. The lock flag is high while any entry is locked.
- R12: The fault output is the inverse of allow. On a fault, fault_kind repeats the access kind; otherwise it is 0.
- R13: An accepted write reports accept high in its cycle and takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W (2) | Entry index for the write |
| cfg_sel_addr | input | 1 | 1 writes the address word, 0 writes the configuration byte |
| cfg_wdata | input | REG_W (32) | Write data; bits 7:0 are used for a configuration write |
| cfg_ok | output | 1 | Write accepted (valid while cfg_we is high) |
| req_addr | input | ADDR_W (34) | Physical address of the access |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| chk_allow | output | 1 | Access may proceed |
| chk_fault | output | 1 | Access is refused |
| fault_kind | output | 2 | Access kind of a refused access, else 0 |
| rule_count | output | CNT_W (3) | Number of entries with a mode other than off |
| any_lock | output | 1 | At least one entry is locked |

## Verification
The bench probes the boundaries of each region on both sides: the last byte inside and the first byte outside. Off-by-one errors in the four-byte, power-of-two and top-of-range decoders then show as a wrong verdict. The same addresses are tried with each access kind, so a swapped permission bit is caught apart from a wrong region. Overlapping entries with different rights separate the lowest-index rule from any other choice. Machine-mode probes, taken before and after a lock and with and without a matching entry, separate the locked, unlocked and no-match paths. Refused writes are followed by probes whose verdict would change had the write landed, including a write to the neighbour's address word that sets a top-of-range lower bound.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  localparam int unsigned PERM_R_BIT  = 0;
  localparam int unsigned PERM_W_BIT  = 1;
  localparam int unsigned PERM_X_BIT  = 2;
  localparam int unsigned MODE_LO_BIT = 3;
  localparam int unsigned LOCK_BIT    = 7;

  localparam logic [1:0] KIND_READ    = 2'd0;
  localparam logic [1:0] KIND_WRITE   = 2'd1;
  localparam logic [1:0] KIND_EXEC    = 2'd2;
  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  function automatic match_mode_e cfg_mode(input logic [7:0] c);
    return match_mode_e'(c[MODE_LO_BIT +: 2]);
  endfunction

  function automatic logic cfg_locked(input logic [7:0] c);
    return c[LOCK_BIT];
  endfunction

endpackage

// File: rtl/pmp_guard_regs.sv
module pmp_guard_regs
  import pmp_guard_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned CNT_W       = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic                               wr_is_addr,
  input  logic [REG_W-1:0]                   wr_data,
  output logic                               wr_accept,
  output logic [NUM_ENTRIES-1:0][7:0]        cfg_tab,
  output logic [NUM_ENTRIES-1:0][REG_W-1:0]  addr_tab,
  output logic [CNT_W-1:0]                   active_cnt,
  output logic                               lock_seen
);

  logic [NUM_ENTRIES-1:0][7:0]       cfg_q, cfg_d;
  logic [NUM_ENTRIES-1:0][REG_W-1:0] addr_q, addr_d;
  logic                              wr_ok;
  logic                              commit;

  // Write permission: own lock, and lock of a top-of-range neighbour above
  always_comb begin
    wr_ok = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (wr_idx == IDX_W'(i)) begin
        wr_ok = !cfg_locked(cfg_q[i]);
        if (wr_is_addr && (i < NUM_ENTRIES - 1)) begin
          if (cfg_locked(cfg_q[(i + 1) % NUM_ENTRIES]) &&
              cfg_mode(cfg_q[(i + 1) % NUM_ENTRIES]) == MODE_TOR)
            wr_ok = 1'b0;
        end
      end
    end
  end

  assign commit    = wr_en && wr_ok;
  assign wr_accept = commit;

  // Next-state
  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (wr_idx == IDX_W'(i)) begin
        if (wr_is_addr) addr_d[i] = wr_data;
        else            cfg_d[i]  = wr_data[7:0];
      end
    end
  end

  // State
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (commit) begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
    end
  end

  // Derived status
  always_comb begin
    active_cnt = '0;
    lock_seen  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (cfg_mode(cfg_q[i]) != MODE_OFF) active_cnt = active_cnt + 1'b1;
      lock_seen = lock_seen | cfg_locked(cfg_q[i]);
    end
  end

  assign cfg_tab  = cfg_q;
  assign addr_tab = addr_q;

  // R9: a refused write leaves the table untouched
  p_refused_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_accept) |=> ($stable(cfg_q) && $stable(addr_q)));

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
    // R9: a lock stays set until reset
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[g][LOCK_BIT] |=> cfg_q[g][LOCK_BIT]);
    // R13: an accepted configuration write lands on the next edge
    p_cfg_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && !wr_is_addr && wr_idx == IDX_W'(g)) |=> cfg_q[g] == $past(wr_data[7:0]));
  end

endmodule

// File: rtl/pmp_guard_match.sv
module pmp_guard_match
  import pmp_guard_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic [REG_W-1:0] req_word,
  input  logic [REG_W-1:0] this_reg,
  input  logic [REG_W-1:0] prev_reg,
  input  match_mode_e      mode,
  output logic             hit
);

  logic [REG_W-1:0] napot_care;

  always_comb begin
    // word ^ (word+1) sets the trailing ones plus the first zero: the size field
    napot_care = ~(this_reg ^ (this_reg + 1'b1));
    case (mode)
      MODE_TOR:   hit = (req_word >= prev_reg) && (req_word < this_reg);
      MODE_NA4:   hit = (req_word == this_reg);
      MODE_NAPOT: hit = ((req_word ^ this_reg) & napot_care) == '0;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_guard_decide.sv
module pmp_guard_decide
  import pmp_guard_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned CNT_W       = 3
) (
  input  logic [NUM_ENTRIES-1:0]      hit,
  input  logic [NUM_ENTRIES-1:0][7:0] cfg_tab,
  input  logic [1:0]                  req_kind,
  input  logic [1:0]                  req_priv,
  input  logic [CNT_W-1:0]            rule_count,
  output logic                        allow
);

  logic       found;
  logic [7:0] win_cfg;
  logic       perm;
  logic       is_machine;
  logic       unused_win;

  always_comb begin
    found   = 1'b0;
    win_cfg = '0;
    // Scan downwards so the lowest matching index is left in place
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found   = 1'b1;
        win_cfg = cfg_tab[i];
      end
    end
    is_machine = (req_priv == PRIV_MACHINE);
    case (req_kind)
      KIND_READ:  perm = win_cfg[PERM_R_BIT];
      KIND_WRITE: perm = win_cfg[PERM_W_BIT];
      KIND_EXEC:  perm = win_cfg[PERM_X_BIT];
      default:    perm = 1'b0;
    endcase
    if (found) allow = (is_machine && !cfg_locked(win_cfg)) || perm;
    else       allow = is_machine || (rule_count == '0);
  end

  assign unused_win = ^win_cfg[6:3];

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmp_guard_pkg::*;
#(
  parameter  int unsigned NUM_ENTRIES = 4,
  parameter  int unsigned ADDR_W      = 34,
  localparam int unsigned REG_W       = ADDR_W - 2,
  localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES),
  localparam int unsigned CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic              cfg_ok,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_priv,
  output logic              chk_allow,
  output logic              chk_fault,
  output logic [1:0]        fault_kind,
  output logic [CNT_W-1:0]  rule_count,
  output logic              any_lock
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_ENTRIES-1:0][7:0]       cfg_tab;
  logic [NUM_ENTRIES-1:0][REG_W-1:0] addr_tab;
  logic [NUM_ENTRIES-1:0]            hit;
  logic [REG_W-1:0]                  req_word;
  logic                              unused_lsb;

  assign req_word   = req_addr[ADDR_W-1:2];
  assign unused_lsb = ^req_addr[1:0];

  pmp_guard_regs #(
    .NUM_ENTRIES(NUM_ENTRIES), .REG_W(REG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_idx),
    .wr_is_addr (cfg_sel_addr),
    .wr_data    (cfg_wdata),
    .wr_accept  (cfg_ok),
    .cfg_tab    (cfg_tab),
    .addr_tab   (addr_tab),
    .active_cnt (rule_count),
    .lock_seen  (any_lock)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [REG_W-1:0] prev_w;
    if (g == 0) begin : g_base
      assign prev_w = '0;
    end else begin : g_chain
      assign prev_w = addr_tab[g-1];
    end
    pmp_guard_match #(.REG_W(REG_W)) match_i (
      .req_word (req_word),
      .this_reg (addr_tab[g]),
      .prev_reg (prev_w),
      .mode     (cfg_mode(cfg_tab[g])),
      .hit      (hit[g])
    );
  end

  pmp_guard_decide #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) decide_i (
    .hit        (hit),
    .cfg_tab    (cfg_tab),
    .req_kind   (req_kind),
    .req_priv   (req_priv),
    .rule_count (rule_count),
    .allow      (chk_allow)
  );

  assign chk_fault  = !chk_allow;
  assign fault_kind = chk_fault ? req_kind : 2'd0;

  // R8: an empty table lets everything through
  p_empty_allow_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rule_count == '0) |-> chk_allow);
  // R10: without any lock, machine mode is never refused
  p_machine_open_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!any_lock && req_priv == PRIV_MACHINE) |-> chk_allow);
  // R11: the count never exceeds the table size
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rule_count <= CNT_W'(NUM_ENTRIES));
  // R1: the table comes out of reset empty
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (rule_count == '0 && !any_lock));

endmodule

// File: tb/pmp_guard_tb_top.sv
module pmp_guard_tb_top;

  localparam int ADDR_W = 34;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic        cfg_sel_addr;
  logic [31:0] cfg_wdata;
  logic        cfg_ok;
  logic [33:0] req_addr;
  logic [1:0]  req_kind, req_priv;
  logic        chk_allow, chk_fault;
  logic [1:0]  fault_kind;
  logic [2:0]  rule_count;
  logic        any_lock;

  always #5 clk = ~clk;

  pmp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel_addr(cfg_sel_addr), .cfg_wdata(cfg_wdata), .cfg_ok(cfg_ok),
    .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .chk_allow(chk_allow), .chk_fault(chk_fault), .fault_kind(fault_kind),
    .rule_count(rule_count), .any_lock(any_lock)
  );

  typedef enum int {W_ALLOW, W_FKIND, W_WOK, W_CNT, W_LOCK} what_e;
  typedef struct {
    what_e what;
    int    exp;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int       n_run  = 0;
  int       n_fail = 0;
  bit       done   = 1'b0;

  function automatic void push(what_e w, int e, string t);
    sb_item_t it;
    it.what = w; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endfunction

  // Monitor: samples 2 ns after each falling edge, when inputs are settled
  always begin
    sb_item_t it;
    int act;
    @(negedge clk);
    #2;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.what)
        W_ALLOW: act = (chk_allow && !chk_fault) ? 1 : ((!chk_allow && chk_fault) ? 0 : 9);
        W_FKIND: act = int'(fault_kind);
        W_WOK:   act = int'(cfg_ok);
        W_CNT:   act = int'(rule_count);
        default: act = int'(any_lock);
      endcase
      n_run++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s: %s actual=%0d expected=%0d", it.tag, it.what.name(), act, it.exp);
      end
    end
  end

  task automatic probe(input logic [33:0] a, input logic [1:0] k, input logic [1:0] p,
                       input int exp, input string tag);
    @(negedge clk);
    req_addr = a; req_kind = k; req_priv = p;
    push(W_ALLOW, exp, tag);
    push(W_FKIND, exp ? 0 : int'(k), {tag, "/R12"});
  endtask

  task automatic wr(input int idx, input bit is_addr, input logic [31:0] d,
                    input int exp_ok, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel_addr = is_addr; cfg_wdata = d;
    push(W_WOK, exp_ok, tag);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic stat(input int cnt, input int lk, input string tag);
    @(negedge clk);
    push(W_CNT, cnt, tag);
    push(W_LOCK, lk, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_sel_addr = 1'b0; cfg_wdata = '0;
    req_addr = '0; req_kind = RD; req_priv = PU;
    stat(0, 0, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R8: empty table
    stat(0, 0, "R1");
    probe(34'h1234, RD, PU, 1, "R1 empty user read");
    probe(34'h1234, EX, PS, 1, "R8 empty supervisor exec");

    // Entry 0: four-byte slot at 0x1000, read only
    wr(0, 1, 32'h400, 1, "R13 addr0");
    wr(0, 0, 32'h11, 1, "R13 cfg0");
    stat(1, 0, "R11 one rule");
    probe(34'h1000, RD, PU, 1, "R5 first byte");
    probe(34'h1003, RD, PU, 1, "R5 last byte");
    probe(34'h1004, RD, PU, 0, "R5 past end");
    probe(34'h0FFF, RD, PU, 0, "R5 before start");
    probe(34'h1000, WR, PU, 0, "R2 no write right");
    probe(34'h1000, WR, PM, 1, "R10 unlocked machine");
    probe(34'h3_0000_0000, RD, PM, 1, "R8 machine no match");

    // Entry 1: power-of-two block 0x2000..0x20FF, read/write
    wr(1, 1, 32'h81F, 1, "R13 addr1");
    wr(1, 0, 32'h1B, 1, "R13 cfg1");
    probe(34'h2000, WR, PU, 1, "R6 base");
    probe(34'h20FF, RD, PS, 1, "R6 top byte");
    probe(34'h2100, WR, PU, 0, "R6 past end");
    probe(34'h1FFF, RD, PU, 0, "R6 below base");
    probe(34'h2010, EX, PU, 0, "R2 no exec right");

    // Entry 2 left off but with all rights
    wr(2, 1, 32'h1000, 1, "R13 addr2");
    wr(2, 0, 32'h07, 1, "R13 cfg2");
    probe(34'h4000, RD, PU, 0, "R3 off never matches");
    stat(2, 0, "R11 two rules");

    // Entry 3: top-of-range 0x4000..0x4FFF, execute only
    wr(3, 1, 32'h1400, 1, "R13 addr3");
    wr(3, 0, 32'h0C, 1, "R13 cfg3");
    probe(34'h4000, EX, PU, 1, "R4 lower bound");
    probe(34'h4FFC, EX, PU, 1, "R4 last word");
    probe(34'h5000, EX, PU, 0, "R4 upper bound excluded");
    probe(34'h3FFC, EX, PU, 0, "R4 below lower");
    stat(3, 0, "R11 three rules");

    // Entry 0 becomes top-of-range from address 0
    wr(0, 1, 32'h40, 1, "R13 addr0 tor");
    wr(0, 0, 32'h09, 1, "R13 cfg0 tor");
    probe(34'h0, RD, PU, 1, "R4 entry0 from zero");
    probe(34'hFF, RD, PU, 1, "R4 entry0 top");
    probe(34'h100, RD, PU, 0, "R4 entry0 end");
    probe(34'h1000, RD, PU, 0, "R3 old slot gone");

    // Priority: entry 2 four-byte exec at 0x2000, inside entry 1
    wr(2, 1, 32'h800, 1, "R13 addr2 move");
    wr(2, 0, 32'h14, 1, "R13 cfg2 na4");
    probe(34'h2000, EX, PU, 0, "R7 lower entry wins");
    probe(34'h2000, RD, PU, 1, "R7 lower entry read");
    probe(34'h2100, EX, PU, 1, "R4 moved lower bound");
    stat(4, 0, "R11 four rules");

    // Lock entry 3 with no rights
    wr(3, 0, 32'h88, 1, "R9 lock write accepted");
    stat(4, 1, "R11 lock flag");
    probe(34'h3000, EX, PM, 0, "R10 locked binds machine");
    probe(34'h3000, RD, PM, 0, "R10 locked read");
    probe(34'h2000, EX, PM, 1, "R10 unlocked lower wins");
    probe(34'h9000, RD, PM, 1, "R8 machine miss");
    probe(34'h9000, RD, PS, 0, "R8 supervisor miss");
    wr(3, 0, 32'h0F, 0, "R9 locked cfg refused");
    probe(34'h3000, EX, PM, 0, "R9 cfg unchanged");
    wr(3, 1, 32'h3FFF, 0, "R9 locked addr refused");
    probe(34'h5000, RD, PM, 1, "R9 top unchanged");
    wr(2, 1, 32'h0, 0, "R9 neighbour addr refused");
    probe(34'h1FF0, RD, PM, 1, "R9 bound unchanged");
    wr(2, 0, 32'h15, 1, "R9 neighbour cfg open");
    wr(1, 1, 32'h0, 1, "R9 other addr open");
    stat(4, 1, "R9 lock held");

    // Reset clears everything including the lock
    @(negedge clk);
    rst_n = 1'b0;
    stat(0, 0, "R1 reset again");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    probe(34'h3000, EX, PU, 1, "R1 table empty");
    wr(3, 0, 32'h00, 1, "R1 lock cleared");
    stat(0, 0, "R1 after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule